// File: doc/BRIEF.md
# Write-Only Two-Wire Register Slave

This block is a slave on a two-wire serial control bus that accepts register writes and nothing else. It watches oversampled copies of the bus clock and data lines, recognises start and stop conditions, and collects the first byte after a start: a 7-bit device address followed by a read/write flag. When that byte names this device with a write request, the block acknowledges by pulling the data line low. It then takes exactly two more bytes, acknowledging each one. Together those two bytes make a 16-bit control word.

After the second acknowledge has finished, the block splits the word into a 7-bit register address and a 9-bit register value and raises a write strobe for one system clock. A wrong address, a read request, or a start or stop that arrives in the middle of a transfer drops the slave back to idle, and no write takes place. The surrounding logic drives the physical line low whenever the pull-low output is set.

Top module: `twsWriteSlave`

## Requirements
- R1: While reset is held and right after it, the pull-low output is 0, the strobe is 0, and the register address and register data outputs are all zero.
- R2: A start is the data line falling while the clock line is high. From idle, a start begins reception of the first byte.
- R3: The first byte arrives MSB first as seven address bits and then the read/write flag. If the address equals 7'b0011010 and the flag is 0, the pull-low is asserted after the eighth clock falls and is held through the high phase of the ninth clock.
- R4: If the address does not match, or the flag is 1, the pull-low is never asserted and no strobe follows. The slave ignores the bus until the next start.
- R5: The two bytes after the address are each acknowledged, and both arrive MSB first. Word bits 15..9 (the high 7 bits of the first byte) form the register address. Word bits 8..0 (bit 0 of the first byte, then the second byte) form the register data.
- R6: The pull-low is released on the clock falling edge that ends each acknowledge slot. It reads 0 no later than SYNC_STAGES+2 system clocks after that edge.
- R7: The write strobe is high for exactly one system clock. It rises only after the falling edge that ends the second data acknowledge. The address and data outputs are valid in that cycle and hold their value until the next strobe.
- R8: A start or stop that arrives before the second data acknowledge completes sends the slave to idle. No strobe follows and the outputs keep their last committed value. A later transfer needs a new start.
- R9: After a completed transfer the slave stays idle until the next start. Further bytes clocked before a stop are not acknowledged and cause no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as sensed |
| sdaIn | input | 1 | Bus data line as sensed |
| sdaPullLow | output | 1 | 1 = drive the data line low (open drain) |
| wrAddr | output | ADDR_W | Register address of the last committed write |
| wrData | output | DATA_W | Register data of the last committed write |
| wrStrobe | output | 1 | One-cycle pulse marking a committed write |

## Verification
A wrong state in the sequencer shows up at the bus within one byte. A stuck or early acknowledge state drives the data line low at the wrong time. The master sees that at the next clock high, or the block reads it as a false stop or start. A slipped bit counter misplaces the acknowledge slot by whole bus clocks, which the bench sees at the ninth pulse of the same byte. A faulty capture of the word shows only when the strobe fires, as an address or data mismatch on that exact transfer. An abort path that fails to return to idle shows as a strobe or an acknowledge where the bench expects neither.

// File: rtl/twsPkg.sv
package twsPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_HIGH,
    ST_HIGH_ACK,
    ST_LOW,
    ST_LOW_ACK
  } twsState_e;

  // Strobes from the sequencer to the datapath, each valid for one cycle.
  typedef struct packed {
    logic shiftBit;  // sample the data line into the byte shifter
    logic clrBits;   // restart byte collection
    logic keepHigh;  // park the finished first data byte
    logic commit;    // copy the full word to the outputs
  } twsCtl_t;

endpackage

// File: rtl/twsLineSync.sv
module twsLineSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  logic [SYNC_STAGES-1:0] sclChain;
  logic [SYNC_STAGES-1:0] sdaChain;
  logic sclPrev;
  logic sdaPrev;
  logic sclNow;
  logic sdaNow;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain[i] <= 1'b1;
          sdaChain[i] <= 1'b1;
        end else begin
          sclChain[i] <= sclIn;
          sdaChain[i] <= sdaIn;
        end
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain[i] <= 1'b1;
          sdaChain[i] <= 1'b1;
        end else begin
          sclChain[i] <= sclChain[i-1];
          sdaChain[i] <= sdaChain[i-1];
        end
      end
    end
  end

  assign sclNow = sclChain[SYNC_STAGES-1];
  assign sdaNow = sdaChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sdaLvl    = sdaNow;
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  // A data edge counts as a bus condition only if the clock was high on both samples.
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;

endmodule

// File: rtl/twsDatapath.sv
module twsDatapath
  import twsPkg::*;
#(
  parameter int         ADDR_W   = 7,
  parameter int         DATA_W   = 9,
  parameter logic [6:0] DEV_ADDR = 7'b0011010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaLvl,
  input  twsCtl_t           ctl,
  output logic              bitsDone,
  output logic              addrHit,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int WORD_W = ADDR_W + DATA_W;

  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] highByte;
  logic [CNT_W-1:0]  bitCnt;
  logic [WORD_W-1:0] fullWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (ctl.clrBits) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (ctl.shiftBit) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaLvl};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highByte <= '0;
    end else if (ctl.keepHigh) begin
      highByte <= shiftReg;
    end
  end

  assign fullWord = {highByte, shiftReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddr <= '0;
      wrData <= '0;
    end else if (ctl.commit) begin
      wrAddr <= fullWord[WORD_W-1 -: ADDR_W];
      wrData <= fullWord[DATA_W-1:0];
    end
  end

  assign bitsDone = (bitCnt == CNT_W'(BYTE_W));
  assign addrHit  = (shiftReg[BYTE_W-1:1] == DEV_ADDR) && !shiftReg[0];

endmodule

// File: rtl/twsControl.sv
module twsControl
  import twsPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclRise,
  input  logic    sclFall,
  input  logic    startSeen,
  input  logic    stopSeen,
  input  logic    bitsDone,
  input  logic    addrHit,
  output twsCtl_t ctl,
  output logic    sdaPullLow,
  output logic    wrStrobe
);

  twsState_e state;
  twsState_e stateNext;
  logic      strobeNext;

  always_comb begin
    stateNext  = state;
    ctl        = '0;
    strobeNext = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startSeen) begin
          stateNext   = ST_ADDR;
          ctl.clrBits = 1'b1;
        end
      end
      ST_ADDR, ST_HIGH, ST_LOW: begin
        if (startSeen || stopSeen) begin
          stateNext = ST_IDLE;
        end else if (sclRise && !bitsDone) begin
          ctl.shiftBit = 1'b1;
        end else if (sclFall && bitsDone) begin
          if (state == ST_ADDR) begin
            stateNext = addrHit ? ST_ADDR_ACK : ST_IDLE;
          end else if (state == ST_HIGH) begin
            stateNext    = ST_HIGH_ACK;
            ctl.keepHigh = 1'b1;
          end else begin
            stateNext = ST_LOW_ACK;
          end
        end
      end
      ST_ADDR_ACK, ST_HIGH_ACK, ST_LOW_ACK: begin
        if (startSeen || stopSeen) begin
          stateNext = ST_IDLE;
        end else if (sclFall) begin
          if (state == ST_ADDR_ACK) begin
            stateNext   = ST_HIGH;
            ctl.clrBits = 1'b1;
          end else if (state == ST_HIGH_ACK) begin
            stateNext   = ST_LOW;
            ctl.clrBits = 1'b1;
          end else begin
            stateNext  = ST_IDLE;
            ctl.commit = 1'b1;
            strobeNext = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wrStrobe <= 1'b0;
    end else begin
      state    <= stateNext;
      wrStrobe <= strobeNext;
    end
  end

  assign sdaPullLow = (state == ST_ADDR_ACK) || (state == ST_HIGH_ACK) ||
                      (state == ST_LOW_ACK);

endmodule

// File: rtl/twsWriteSlave.sv
module twsWriteSlave
  import twsPkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_W      = 7,
  parameter int         DATA_W      = 9,
  parameter logic [6:0] DEV_ADDR    = 7'b0011010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrStrobe
);

  logic    sdaLvl;
  logic    sclRise;
  logic    sclFall;
  logic    startSeen;
  logic    stopSeen;
  logic    bitsDone;
  logic    addrHit;
  twsCtl_t ctl;

  twsLineSync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  twsControl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .bitsDone(bitsDone),
    .addrHit(addrHit), .ctl(ctl), .sdaPullLow(sdaPullLow),
    .wrStrobe(wrStrobe)
  );

  twsDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .sdaLvl(sdaLvl), .ctl(ctl),
    .bitsDone(bitsDone), .addrHit(addrHit), .wrAddr(wrAddr), .wrData(wrData)
  );

endmodule

// File: rtl/twsWriteSlaveChecker.sv
module twsWriteSlaveChecker #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaPullLow,
  input logic              wrStrobe,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              sclFall,
  input logic              startSeen,
  input logic              stopSeen
);

  // R3: once asserted, the pull-low stays until a clock fall or a bus condition
  p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullLow && !sclFall && !startSeen && !stopSeen) |=> sdaPullLow);

  // R3: the pull-low only starts right after a clock fall
  p_ack_enter_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> $past(sclFall));

  // R6: release follows a clock fall or an abort
  p_ack_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> ($past(sclFall) || $past(startSeen) || $past(stopSeen)));

  // R7: strobe is a single-cycle pulse
  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R7: strobe follows the clock fall that ended an acknowledge
  p_strobe_after_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrStrobe) |-> ($past(sclFall) && $past(sdaPullLow)));

  // R8: outputs change only together with the strobe
  p_outputs_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> ($stable(wrAddr) && $stable(wrData)));

  // R8: a bus condition leaves no acknowledge and no strobe behind
  p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (startSeen || stopSeen) |=> (!sdaPullLow && !wrStrobe));

endmodule

bind twsWriteSlave twsWriteSlaveChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .sdaPullLow(sdaPullLow), .wrStrobe(wrStrobe),
  .wrAddr(wrAddr), .wrData(wrData), .sclFall(sclFall),
  .startSeen(startSeen), .stopSeen(stopSeen)
);

// File: tb/twsWriteSlave_tb.sv
module twsWriteSlave_tb;

  localparam int         HALF     = 8;
  localparam logic [6:0] DEV      = 7'b0011010;
  localparam int         RELEASE  = 5;  // cycles after a fall to see the pull-low gone

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaLine;
  logic       sdaPullLow;
  logic [6:0] wrAddr;
  logic [8:0] wrData;
  logic       wrStrobe;

  int checkCnt = 0;
  int failCnt  = 0;
  int strobeCnt = 0;
  bit done = 1'b0;
  logic [15:0] expQ[$];
  logic [6:0] lastAddr = '0;
  logic [8:0] lastData = '0;
  logic prevStrobe = 1'b0;

  always #4 clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullLow;

  twsWriteSlave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .wrAddr(wrAddr), .wrData(wrData),
    .wrStrobe(wrStrobe)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitN(HALF);
    sclM = 1'b1; waitN(HALF);
    sdaM = 1'b0; waitN(HALF);
    sclM = 1'b0; waitN(HALF);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitN(HALF);
    sclM = 1'b1; waitN(HALF);
    sdaM = 1'b1; waitN(HALF);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b;    waitN(HALF);
    sclM = 1'b1; waitN(HALF);
    sclM = 1'b0;
  endtask

  // Eight bits MSB first, then the acknowledge slot with its checks.
  task automatic sendByte(input logic [7:0] val, input bit expAck, input string req);
    for (int i = 7; i >= 0; i--) sendBit(val[i]);
    sdaM = 1'b1; waitN(HALF);
    check(sdaPullLow == expAck, {req, " ack asserted before ninth clock"}, sdaPullLow, expAck);
    sclM = 1'b1; waitN(HALF);
    check(sdaLine == !expAck, {req, " line level at ninth clock high"}, sdaLine, !expAck);
    sclM = 1'b0; waitN(RELEASE);
    check(sdaPullLow == 1'b0, "R6 pull-low released after ninth fall", sdaPullLow, 0);
  endtask

  task automatic doWrite(input logic [6:0] ra, input logic [8:0] rd);
    busStart();
    sendByte({DEV, 1'b0}, 1'b1, "R2 R3 address byte");
    sendByte({ra, rd[8]}, 1'b1, "R5 first data byte");
    expQ.push_back({ra, rd});
    sendByte(rd[7:0], 1'b1, "R5 second data byte");
    lastAddr = ra;
    lastData = rd;
    busStop();
  endtask

  task automatic checkUnchanged(input string req);
    check(wrAddr == lastAddr, {req, " address held"}, wrAddr, lastAddr);
    check(wrData == lastData, {req, " data held"}, wrData, lastData);
  endtask

  // Monitor: scoreboard pops one expected word per strobe.
  always @(negedge clk) begin
    if (rstN) begin
      if (wrStrobe) begin
        strobeCnt++;
        check(!prevStrobe, "R7 strobe one cycle wide", prevStrobe, 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R8 R9 unexpected strobe", {wrAddr, wrData}, 0);
        end else begin
          logic [15:0] want;
          want = expQ.pop_front();
          check({wrAddr, wrData} == want, "R5 R7 committed word", {wrAddr, wrData}, want);
        end
      end
      prevStrobe = wrStrobe;
    end
  end

  initial begin
    waitN(4);
    check(sdaPullLow == 1'b0, "R1 pull-low in reset", sdaPullLow, 0);
    check(wrStrobe == 1'b0, "R1 strobe in reset", wrStrobe, 0);
    check({wrAddr, wrData} == 16'h0, "R1 outputs in reset", {wrAddr, wrData}, 0);
    rstN = 1'b1;
    waitN(3);
    check(sdaPullLow == 1'b0 && wrStrobe == 1'b0, "R1 quiet after reset",
          {sdaPullLow, wrStrobe}, 0);

    // Main function with several word patterns
    doWrite(7'h01, 9'h1A5);
    doWrite(7'h7F, 9'h000);
    doWrite(7'h2A, 9'h155);
    doWrite(7'h00, 9'h1FF);
    check(wrAddr == 7'h00 && wrData == 9'h1FF, "R7 outputs hold after strobe",
          {wrAddr, wrData}, {7'h00, 9'h1FF});

    // R4: wrong device address
    busStart();
    sendByte({7'b0011011, 1'b0}, 1'b0, "R4 mismatched address");
    sendByte(8'h55, 1'b0, "R4 ignored byte");
    sendByte(8'hAA, 1'b0, "R4 ignored byte");
    busStop();
    checkUnchanged("R4 mismatch");

    // R4: read request to the right address
    busStart();
    sendByte({DEV, 1'b1}, 1'b0, "R4 read request");
    sendByte(8'hFF, 1'b0, "R4 ignored byte");
    busStop();
    checkUnchanged("R4 read");

    // R8: stop after the first data byte
    busStart();
    sendByte({DEV, 1'b0}, 1'b1, "R3 address byte");
    sendByte(8'h3C, 1'b1, "R5 first data byte");
    busStop();
    checkUnchanged("R8 stop abort");
    doWrite(7'h13, 9'h0C3);

    // R8: start inside the second data byte, then a byte that must be ignored
    busStart();
    sendByte({DEV, 1'b0}, 1'b1, "R3 address byte");
    sendByte(8'h81, 1'b1, "R5 first data byte");
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    sdaM = 1'b1; waitN(HALF);
    sclM = 1'b1; waitN(HALF);
    sdaM = 1'b0; waitN(HALF);
    sclM = 1'b0; waitN(HALF);
    sendByte({DEV, 1'b0}, 1'b0, "R8 no ack after start abort");
    busStop();
    checkUnchanged("R8 start abort");

    // R9: extra byte after a complete transfer
    busStart();
    sendByte({DEV, 1'b0}, 1'b1, "R3 address byte");
    sendByte({7'h44, 1'b0}, 1'b1, "R5 first data byte");
    expQ.push_back({7'h44, 9'h0E7});
    sendByte(8'hE7, 1'b1, "R5 second data byte");
    lastAddr = 7'h44;
    lastData = 9'h0E7;
    sendByte(8'h34, 1'b0, "R9 extra byte not acknowledged");
    busStop();
    checkUnchanged("R9 extra byte");

    doWrite(7'h55, 9'h0AA);
    waitN(20);
    check(expQ.size() == 0, "R7 every expected write seen", expQ.size(), 0);
    check(strobeCnt == 7, "R7 R8 R9 strobe count", strobeCnt, 7);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

endmodule